// File: doc/BRIEF.md
# Dual-Mode Interrupt Status Controller

This block collects interrupt causes for a small register-mapped peripheral. Causes come from software writes to a raise register, from the device core as a cause word, and from a computation-finished event when software has enabled it. Every raise ORs its cause into a 32-bit accumulated status word. Software reads that word, handles the causes, and clears them by writing the handled bits to an acknowledge register.

The host is notified in one of two ways, chosen by a configuration input. In legacy mode the block drives a level interrupt line. The line rises on a raise that leaves the status nonzero, and it falls on an acknowledge that empties the status. In message mode the block emits a one-cycle message request for vector 0 on every raise that leaves the status nonzero. In that mode an acknowledge only clears status bits and never moves the line, but software must still acknowledge.

Top module: `irq_dualmode_ctrl`

## Requirements
- R1: A raise ORs its value into the status word. Bits already set stay set. A software write to offset 0x60 is a raise whose value is the write data.
- R2: A write to offset 0x64 is an acknowledge. It clears the written bits from the status word (status AND NOT data).
- R3: If a raise and an acknowledge occur in the same cycle, the clear is applied first and the OR second. Bits raised in that cycle always end up set.
- R4: With msi_en low, a raise that leaves the status nonzero drives irq_level high from the next cycle. No msi_req pulse is produced.
- R5: With msi_en high, every raise that leaves the status nonzero produces a one-cycle msi_req pulse in the next cycle. This holds even when the raised bits were already set. A raise that leaves the status zero produces no pulse.
- R6: With msi_en low, an acknowledge that leaves the status zero drives irq_level low in the next cycle. An acknowledge that leaves bits pending keeps the line high.
- R7: With msi_en high, irq_level never changes. An acknowledge changes only the status bits.
- R8: After reset the status word is zero, irq_level and msi_req are low, and the done-enable bit is clear.
- R9: A read at offset 0x24 returns the status word. Writes to 0x24 are ignored.
- R10: Offset 0x20 is the control word. Bit 7 is a read/write done-enable. Bit 0 reads the core_busy input and ignores writes. All other bits read as zero.
- R11: A core_done pulse raises cause 0x1 when the done-enable bit is set. It has no effect when the bit is clear.
- R12: A core_raise pulse raises with the value on core_cause, exactly like a software raise.
- R13: rd_data is registered and holds the addressed word in the cycle after rd_en. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Registered read data |
| core_raise | input | 1 | Raise request from the device core |
| core_cause | input | 32 | Cause value of a core raise |
| core_done | input | 1 | Computation-finished pulse |
| core_busy | input | 1 | Computation-in-progress flag |
| msi_en | input | 1 | Selects message mode when high |
| irq_level | output | 1 | Level interrupt line (legacy mode) |
| msi_req | output | 1 | One-cycle message request, vector 0 |

## Verification
A corrupted status bit shows up on the next status read. In legacy mode it shows up sooner: the line stays high after an acknowledge that should have emptied the status, in the cycle right after that acknowledge. A wrong clear-versus-raise order on a shared cycle loses a just-raised bit, which the read after that cycle exposes. A wrong mode decision shows up in the cycle after the raise, either as a missing or spurious msi_req pulse or as a line that moves while message mode is selected.

// File: rtl/irq_dm_pkg.sv
package irq_dm_pkg;
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_CTRL  = 3'd1,
    SEL_STAT  = 3'd2,
    SEL_RAISE = 3'd3,
    SEL_ACK   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irq_dm_regif.sv
module irq_dm_regif
  import irq_dm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_CTRL  = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_STAT  = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_RAISE = 8'h60,
  parameter logic [ADDR_W-1:0] OFS_ACK   = 8'h64,
  parameter int BUSY_BIT = 0,
  parameter int DONE_EN_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] status_q,
  input  logic              core_busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              sw_raise_v,
  output logic              sw_ack_v,
  output logic              done_en
);

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == OFS_CTRL)       return SEL_CTRL;
    else if (a == OFS_STAT)  return SEL_STAT;
    else if (a == OFS_RAISE) return SEL_RAISE;
    else if (a == OFS_ACK)   return SEL_ACK;
    else                     return SEL_NONE;
  endfunction

  reg_sel_e wsel, rsel;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rd_mux;

  assign wsel = wr_en ? decode(wr_addr) : SEL_NONE;
  assign rsel = decode(rd_addr);

  assign sw_raise_v = (wsel == SEL_RAISE);
  assign sw_ack_v   = (wsel == SEL_ACK);

  // done-enable: the only writable control bit
  always_ff @(posedge clk) begin
    if (rst) done_en <= 1'b0;
    else if (wsel == SEL_CTRL) done_en <= wr_data[DONE_EN_BIT];
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[DONE_EN_BIT] = done_en;
    ctrl_word[BUSY_BIT]    = core_busy;
  end

  always_comb begin
    unique case (rsel)
      SEL_CTRL: rd_mux = ctrl_word;
      SEL_STAT: rd_mux = status_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R10: control write with bit clear leaves enable clear next cycle
  assert_ctrl_wr_R10: assert property (@(posedge clk) disable iff (rst)
    (wsel == SEL_CTRL && !wr_data[DONE_EN_BIT]) |=> !done_en);

  // R13: an unmapped read yields zero
  assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rsel == SEL_NONE) |=> (rd_data == '0));

endmodule

// File: rtl/irq_dm_status.sv
module irq_dm_status #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raise_v,
  input  logic [DATA_W-1:0] raise_val,
  input  logic              ack_v,
  input  logic [DATA_W-1:0] ack_val,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] status_nxt
);

  // per-bit accumulator: clear first, then OR in the raise
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic keep, set;
    assign keep = status_q[g] & ~(ack_v & ack_val[g]);
    assign set  = raise_v & raise_val[g];
    assign status_nxt[g] = keep | set;
    always_ff @(posedge clk) begin
      if (rst) status_q[g] <= 1'b0;
      else     status_q[g] <= status_nxt[g];
    end
  end

  assert_raise_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (raise_v && !ack_v) |=> ((status_q & $past(raise_val)) == $past(raise_val)));

  assert_ack_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (ack_v && !raise_v) |=> ((status_q & $past(ack_val)) == '0));

  assert_raise_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (ack_v && raise_v) |=> ((status_q & $past(raise_val)) == $past(raise_val)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!ack_v && !raise_v) |=> $stable(status_q));

endmodule

// File: rtl/irq_dm_signal.sv
module irq_dm_signal #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msi_en,
  input  logic              raise_evt,
  input  logic              ack_evt,
  input  logic [DATA_W-1:0] status_nxt,
  input  logic [DATA_W-1:0] status_q,
  output logic              irq_level,
  output logic              msi_req
);

  logic pending_nxt;
  logic level_set, level_clr;

  assign pending_nxt = |status_nxt;
  assign level_set   = !msi_en && raise_evt && pending_nxt;
  assign level_clr   = !msi_en && ack_evt && !pending_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= 1'b0;
      msi_req   <= 1'b0;
    end else begin
      msi_req <= msi_en && raise_evt && pending_nxt;
      if (level_set)      irq_level <= 1'b1;
      else if (level_clr) irq_level <= 1'b0;
    end
  end

  assert_legacy_raise_R4: assert property (@(posedge clk) disable iff (rst)
    (!msi_en && raise_evt && pending_nxt) |=> (irq_level && !msi_req));

  assert_msg_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (msi_en && raise_evt && pending_nxt) |=> msi_req);

  assert_msg_mode_only_R5: assert property (@(posedge clk) disable iff (rst)
    msi_req |-> $past(msi_en));

  assert_line_drop_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_level) |-> ($past(!msi_en) && status_q == '0));

  assert_msg_line_hold_R7: assert property (@(posedge clk) disable iff (rst)
    msi_en |=> $stable(irq_level));

endmodule

// File: rtl/irq_dualmode_ctrl.sv
module irq_dualmode_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_CTRL  = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_STAT  = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_RAISE = 8'h60,
  parameter logic [ADDR_W-1:0] OFS_ACK   = 8'h64,
  parameter logic [DATA_W-1:0] DONE_CAUSE = 32'h1,
  parameter int BUSY_BIT = 0,
  parameter int DONE_EN_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              core_raise,
  input  logic [DATA_W-1:0] core_cause,
  input  logic              core_done,
  input  logic              core_busy,
  input  logic              msi_en,
  output logic              irq_level,
  output logic              msi_req
);

  logic              sw_raise_v, sw_ack_v, done_en, done_v;
  logic              raise_evt;
  logic [DATA_W-1:0] raise_val, status_q, status_nxt;

  irq_dm_regif #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .OFS_CTRL(OFS_CTRL), .OFS_STAT(OFS_STAT),
    .OFS_RAISE(OFS_RAISE), .OFS_ACK(OFS_ACK),
    .BUSY_BIT(BUSY_BIT), .DONE_EN_BIT(DONE_EN_BIT)
  ) u_regif (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .status_q(status_q), .core_busy(core_busy),
    .rd_data(rd_data),
    .sw_raise_v(sw_raise_v), .sw_ack_v(sw_ack_v), .done_en(done_en)
  );

  // merge all raise sources into one event and one cause word
  assign done_v    = core_done && done_en;
  assign raise_evt = sw_raise_v || core_raise || done_v;
  assign raise_val = ({DATA_W{sw_raise_v}} & wr_data)
                   | ({DATA_W{core_raise}} & core_cause)
                   | ({DATA_W{done_v}}     & DONE_CAUSE);

  irq_dm_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst),
    .raise_v(raise_evt), .raise_val(raise_val),
    .ack_v(sw_ack_v), .ack_val(wr_data),
    .status_q(status_q), .status_nxt(status_nxt)
  );

  irq_dm_signal #(.DATA_W(DATA_W)) u_signal (
    .clk(clk), .rst(rst),
    .msi_en(msi_en), .raise_evt(raise_evt), .ack_evt(sw_ack_v),
    .status_nxt(status_nxt), .status_q(status_q),
    .irq_level(irq_level), .msi_req(msi_req)
  );

  // R11: a done pulse with enable set leaves the done cause pending
  assert_done_raise_R11: assert property (@(posedge clk) disable iff (rst)
    (core_done && done_en && !sw_ack_v) |=> ((status_q & DONE_CAUSE) == DONE_CAUSE));

endmodule

// File: tb/irq_dualmode_ctrl_bench.sv
module irq_dualmode_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en, core_raise, core_done, core_busy, msi_en;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, core_cause, rd_data;
  logic        irq_level, msi_req;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  irq_dualmode_ctrl u_irq_dualmode_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .core_raise(core_raise), .core_cause(core_cause), .core_done(core_done),
    .core_busy(core_busy), .msi_en(msi_en),
    .irq_level(irq_level), .msi_req(msi_req)
  );

  typedef struct packed {
    logic        rv;    // core raise
    logic [31:0] rval;
    logic        av;    // acknowledge write to 0x64
    logic [31:0] aval;
    logic        msi;
    logic [31:0] e_st;
    logic        e_lvl;
    logic        e_msi;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 32'h5,  1'b0, 32'h0,  1'b0, 32'h5,  1'b1, 1'b0}, // R1 R4 R12
    '{1'b1, 32'h5,  1'b0, 32'h0,  1'b0, 32'h5,  1'b1, 1'b0}, // R1 repeat
    '{1'b0, 32'h0,  1'b1, 32'h1,  1'b0, 32'h4,  1'b1, 1'b0}, // R2 R6 partial
    '{1'b0, 32'h0,  1'b1, 32'h4,  1'b0, 32'h0,  1'b0, 1'b0}, // R6 drop
    '{1'b1, 32'h10, 1'b1, 32'h10, 1'b0, 32'h10, 1'b1, 1'b0}, // R3
    '{1'b0, 32'h0,  1'b1, 32'h10, 1'b0, 32'h0,  1'b0, 1'b0}, // R6
    '{1'b1, 32'h2,  1'b0, 32'h0,  1'b1, 32'h2,  1'b0, 1'b1}, // R5
    '{1'b1, 32'h2,  1'b0, 32'h0,  1'b1, 32'h2,  1'b0, 1'b1}, // R5 repeat bits
    '{1'b0, 32'h0,  1'b1, 32'h2,  1'b1, 32'h0,  1'b0, 1'b0}, // R7
    '{1'b1, 32'h8,  1'b0, 32'h0,  1'b0, 32'h8,  1'b1, 1'b0}, // R4
    '{1'b0, 32'h0,  1'b1, 32'h8,  1'b1, 32'h0,  1'b1, 1'b0}, // R7 line held
    '{1'b0, 32'h0,  1'b1, 32'h0,  1'b0, 32'h0,  1'b0, 1'b0}, // R6 empty ack
    '{1'b1, 32'h0,  1'b0, 32'h0,  1'b1, 32'h0,  1'b0, 1'b0}, // R5 zero raise
    '{1'b1, 32'h1,  1'b1, 32'h1,  1'b1, 32'h1,  1'b0, 1'b1}, // R3 R5
    '{1'b0, 32'h0,  1'b1, 32'h1,  1'b1, 32'h0,  1'b0, 1'b0}  // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; core_raise = 0; core_done = 0;
    wr_addr = 0; rd_addr = 0; wr_data = 0; core_cause = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(); core_busy = 0; msi_en = 0; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R8 reset state
    chk("R8 level", {31'b0, irq_level}, 0);
    chk("R8 msi", {31'b0, msi_req}, 0);
    rd(8'h24, d); chk("R8 status", d, 0);
    rd(8'h20, d); chk("R8 ctrl", d, 0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      msi_en = TBL[i].msi;
      core_raise = TBL[i].rv; core_cause = TBL[i].rval;
      wr_en = TBL[i].av; wr_addr = 8'h64; wr_data = TBL[i].aval;
      @(negedge clk);
      idle();
      chk($sformatf("R4/R5/R6/R7 level v%0d", i), {31'b0, irq_level}, {31'b0, TBL[i].e_lvl});
      chk($sformatf("R5 msi v%0d", i), {31'b0, msi_req}, {31'b0, TBL[i].e_msi});
      rd_en = 1; rd_addr = 8'h24;
      @(negedge clk); rd_en = 0;
      chk($sformatf("R1/R2/R3/R12 status v%0d", i), rd_data, TBL[i].e_st);
    end
    msi_en = 0;

    // R1 software raise via 0x60, legacy line
    wr(8'h60, 32'hA0);
    chk("R1 sw raise level", {31'b0, irq_level}, 1);
    rd(8'h24, d); chk("R1 sw raise status", d, 32'hA0);
    // R9 writes to status ignored
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, d); chk("R9 status write ignored", d, 32'hA0);
    wr(8'h24, 32'h0);
    rd(8'h24, d); chk("R9 status write zero ignored", d, 32'hA0);
    chk("R9 level kept", {31'b0, irq_level}, 1);
    wr(8'h64, 32'hA0);
    chk("R6 sw ack drop", {31'b0, irq_level}, 0);

    // R10 control word
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R10 ctrl rw", d, 32'h80);
    core_busy = 1;
    rd(8'h20, d); chk("R10 busy bit", d, 32'h81);
    core_busy = 0;

    // R11 done with enable set
    @(negedge clk); core_done = 1;
    @(negedge clk); core_done = 0;
    chk("R11 done level", {31'b0, irq_level}, 1);
    rd(8'h24, d); chk("R11 done cause", d, 32'h1);
    wr(8'h64, 32'h1);
    wr(8'h20, 32'h0);
    rd(8'h20, d); chk("R10 enable cleared", d, 32'h0);
    @(negedge clk); core_done = 1;
    @(negedge clk); core_done = 0;
    chk("R11 done disabled level", {31'b0, irq_level}, 0);
    rd(8'h24, d); chk("R11 done disabled status", d, 32'h0);

    // R13 unmapped read and read latency
    rd(8'h40, d); chk("R13 unmapped", d, 0);
    wr(8'h60, 32'h3);
    @(negedge clk); rd_en = 1; rd_addr = 8'h24;
    @(negedge clk); rd_en = 0; rd_addr = 8'h40;
    chk("R13 read data next cycle", rd_data, 32'h3);
    @(negedge clk);
    chk("R13 rd_data held", rd_data, 32'h3);

    // R5 consecutive raises in message mode pulse each cycle
    msi_en = 1;
    @(negedge clk); core_raise = 1; core_cause = 32'h3;
    @(negedge clk);
    chk("R5 back-to-back first", {31'b0, msi_req}, 1);
    @(negedge clk); core_raise = 0;
    chk("R5 back-to-back second", {31'b0, msi_req}, 1);
    @(negedge clk);
    chk("R5 pulse ends", {31'b0, msi_req}, 0);
    chk("R7 level held in msg mode", {31'b0, irq_level}, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule